// File: doc/BRIEF.md
# Virtual Interrupt Completion Unit

This block finishes the life of a virtual interrupt inside a virtualized CPU interface. A completion write carries an interrupt ID and a group bit. It always retires the most urgent level held in an active-priority tracker. It then looks for a list entry that holds that ID in the active state and, if the guest's group and priority level agree with what was just retired, clears the entry's active flag. When an entry is tied to a physical interrupt, clearing it sends a one-cycle deactivate pulse that carries the physical ID. A second write type, the explicit deactivate, only acts when completion is split into two steps. It then clears a matching entry without the priority step.

Completions and deactivates that find nothing to work on are not errors. They advance a small wrapping miss counter that the hypervisor reads later. IDs at or above a threshold (message-based interrupts) never advance that counter on a completion miss, and are never handled by the explicit deactivate. The list entries and the active-priority levels are loaded through simple strobed ports. A registered read port reports whether an entry is active, and a registered output reports the most urgent active level.

Top module: `virq_eoi_unit`

## Requirements
- R1: After reset the miss counter is 0, no deactivate pulse is present, every list entry reads inactive and the running priority reads 8'hFF (idle).
- R2: A priority-set strobe marks the level of its priority. The priority is first masked by the group's binary point (group 0 clears the low bpr0+1 bits, group 1 clears the low bpr1 bits) and then shifted right by 8-PRE_BITS. Two cycles after the strobe, run_prio shows the lowest marked level shifted back left.
- R3: Every completion strobe clears the lowest marked level, whatever happens to the list entries afterwards.
- R4: The search matches an entry whose ID equals the written ID and whose active flag is set. Inactive entries are skipped, and the lowest-indexed match wins.
- R5: A completion that finds no match adds one to the miss counter when the ID is below LPI_BASE (8192), and leaves it unchanged for IDs of 8192 and above.
- R6: With split_mode high, a completion for an ID below 8192 does not clear the matched entry. For an ID of 8192 or above it still does.
- R7: A matched completion does not clear the entry, and does not change the counter, in two cases: the entry's group differs from the written group, or the entry's priority, masked by the written group's binary point, differs from the level retired in the same cycle.
- R8: Clearing an entry resets its active flag. If its hardware flag is set, deact_valid is high for exactly one cycle, starting one cycle after the strobe, with deact_pid equal to the entry's physical ID. If the hardware flag is clear, no pulse is produced.
- R9: A deactivate strobe has no effect on entries, the counter or deact_valid when split_mode is low or when its ID is 8192 or above.
- R10: With split_mode high, a deactivate strobe for an ID below 8192 clears the first matching active entry with no group or level check. If nothing matches, it adds one to the miss counter.
- R11: The miss counter is CNT_W (5) bits wide and wraps from 31 to 0.
- R12: When a completion and a deactivate strobe arrive in the same cycle, only the completion is processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| split_mode | input | 1 | 1: priority retire and deactivation are separate writes |
| bpr0 | input | 3 | Group 0 binary point |
| bpr1 | input | 3 | Group 1 binary point |
| ld_valid | input | 1 | Load strobe for one list entry |
| ld_idx | input | IDX_W (3) | Entry index to load |
| ld_vid | input | 16 | Virtual interrupt ID |
| ld_pid | input | 13 | Physical interrupt ID |
| ld_prio | input | 8 | Entry priority |
| ld_grp | input | 1 | Entry group |
| ld_hw | input | 1 | Entry is linked to a physical interrupt |
| ld_active | input | 1 | Entry active flag |
| ap_set_valid | input | 1 | Mark an active priority level |
| ap_set_grp | input | 1 | Group of the level to mark |
| ap_set_prio | input | 8 | Priority whose level is marked |
| eoi_valid | input | 1 | Completion write strobe |
| eoi_grp | input | 1 | Group of the completion write |
| eoi_id | input | 16 | ID of the completion write |
| dir_valid | input | 1 | Explicit deactivate strobe |
| dir_id | input | 16 | ID of the deactivate write |
| rd_idx | input | IDX_W (3) | Entry to report |
| rd_active | output | 1 | Registered active flag of entry rd_idx |
| run_prio | output | 8 | Registered most urgent active level, 8'hFF when idle |
| eoi_count | output | CNT_W (5) | Wrapping miss counter |
| deact_valid | output | 1 | One-cycle physical deactivate pulse |
| deact_pid | output | 13 | Physical ID sent with the pulse |

## Verification
A wrong search result shows up one cycle after the strobe. Either the pulse carries the physical ID of the wrong entry, or a hit wrongly advances the miss counter, or a miss wrongly leaves the counter unchanged. A tracker that retires the wrong level, or none at all, turns later matched completions into silent no-ops. That is visible as an entry that still reads active, and as a running priority that does not return to 8'hFF two cycles after the completion. A mishandled split or threshold condition shows as an entry cleared, or kept, against the rule. The effect is visible on the read port one cycle after the strobe.

// File: rtl/virq_eoi_pkg.sv
package virq_eoi_pkg;

  localparam int VID_W  = 16;
  localparam int PID_W  = 13;
  localparam int PRIO_W = 8;

  typedef struct packed {
    logic              hw;
    logic              grp;
    logic              active;
    logic [PRIO_W-1:0] prio;
    logic [PID_W-1:0]  pid;
    logic [VID_W-1:0]  vid;
  } lr_entry_t;

  // Mask a priority down to its preemption part for the given group.
  function automatic logic [PRIO_W-1:0] pre_level(
    input logic [PRIO_W-1:0] prio,
    input logic              grp,
    input logic [2:0]        bp0,
    input logic [2:0]        bp1
  );
    logic [3:0]        sh;
    logic [PRIO_W-1:0] msk;
    sh  = grp ? {1'b0, bp1} : ({1'b0, bp0} + 4'd1);
    msk = {PRIO_W{1'b1}} << sh;
    return prio & msk;
  endfunction

endpackage

// File: rtl/virq_lr_bank.sv
module virq_lr_bank
  import virq_eoi_pkg::*;
#(
  parameter  int NUM_LR = 8,
  localparam int IDX_W  = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_valid,
  input  logic [IDX_W-1:0] ld_idx,
  input  lr_entry_t        ld_entry,
  input  logic             clr_valid,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [VID_W-1:0] srch_id,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output lr_entry_t        hit_entry,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_active
);

  lr_entry_t ent_q [NUM_LR];

  // One register set per entry; a load replaces the entry, a clear drops
  // only its active flag.
  for (genvar g = 0; g < NUM_LR; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_q[g].active <= 1'b0;
      end else if (ld_valid && ld_idx == IDX_W'(g)) begin
        ent_q[g] <= ld_entry;
      end else if (clr_valid && clr_idx == IDX_W'(g)) begin
        ent_q[g].active <= 1'b0;
      end
    end
  end

  // Parallel compare; scanning downward leaves the lowest index as winner.
  always_comb begin
    hit       = 1'b0;
    hit_idx   = '0;
    hit_entry = '0;
    for (int i = NUM_LR - 1; i >= 0; i--) begin
      if (ent_q[i].active && ent_q[i].vid == srch_id) begin
        hit       = 1'b1;
        hit_idx   = IDX_W'(i);
        hit_entry = ent_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_active <= 1'b0;
    else     rd_active <= ent_q[rd_idx].active;
  end

endmodule

// File: rtl/virq_apr_tracker.sv
module virq_apr_tracker
  import virq_eoi_pkg::*;
#(
  parameter  int PRE_BITS = 5,
  localparam int NLVL     = 1 << PRE_BITS,
  localparam int LVL_W    = PRE_BITS,
  localparam int SHIFT    = PRIO_W - PRE_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_valid,
  input  logic              set_grp,
  input  logic [PRIO_W-1:0] set_pre,
  input  logic              drop_valid,
  output logic [PRIO_W-1:0] act_prio,
  output logic [PRIO_W-1:0] run_prio
);

  logic [NLVL-1:0]  map0_q, map1_q, map0_d, map1_d;
  logic [NLVL-1:0]  both;
  logic             any_act;
  logic [LVL_W-1:0] low_idx;
  logic [LVL_W-1:0] set_lvl;

  assign both    = map0_q | map1_q;
  assign any_act = |both;
  assign set_lvl = set_pre[PRIO_W-1:SHIFT];

  always_comb begin
    low_idx = '0;
    for (int i = NLVL - 1; i >= 0; i--) begin
      if (both[i]) low_idx = LVL_W'(i);
    end
  end

  assign act_prio = any_act ? (PRIO_W'(low_idx) << SHIFT) : {PRIO_W{1'b1}};

  // On a tie at the lowest level the group 1 bit goes first.
  always_comb begin
    map0_d = map0_q;
    map1_d = map1_q;
    if (drop_valid && any_act) begin
      if (map1_q[low_idx]) map1_d[low_idx] = 1'b0;
      else                 map0_d[low_idx] = 1'b0;
    end
    if (set_valid) begin
      if (set_grp) map1_d[set_lvl] = 1'b1;
      else         map0_d[set_lvl] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      map0_q   <= '0;
      map1_q   <= '0;
      run_prio <= {PRIO_W{1'b1}};
    end else begin
      map0_q   <= map0_d;
      map1_q   <= map1_d;
      run_prio <= act_prio;
    end
  end

endmodule

// File: rtl/virq_eoi_decide.sv
module virq_eoi_decide
  import virq_eoi_pkg::*;
#(
  parameter int LPI_BASE = 8192
) (
  input  logic              eoi_valid,
  input  logic              eoi_grp,
  input  logic [VID_W-1:0]  eoi_id,
  input  logic              dir_valid,
  input  logic [VID_W-1:0]  dir_id,
  input  logic              split_mode,
  input  logic [2:0]        bpr0,
  input  logic [2:0]        bpr1,
  input  logic              hit,
  input  lr_entry_t         hit_entry,
  input  logic [PRIO_W-1:0] act_prio,
  output logic [VID_W-1:0]  srch_id,
  output logic              do_drop,
  output logic              do_clear,
  output logic              do_bump,
  output logic              do_phys,
  output logic [PID_W-1:0]  phys_id
);

  localparam logic [VID_W-1:0] LPI_TH = VID_W'(LPI_BASE);

  logic              eoi_lpi, dir_lpi, agree;
  logic [PRIO_W-1:0] ent_pre;

  assign srch_id = eoi_valid ? eoi_id : dir_id;
  assign eoi_lpi = eoi_id >= LPI_TH;
  assign dir_lpi = dir_id >= LPI_TH;
  assign ent_pre = pre_level(hit_entry.prio, eoi_grp, bpr0, bpr1);
  assign agree   = (hit_entry.grp == eoi_grp) && (ent_pre == act_prio);

  always_comb begin
    do_drop  = 1'b0;
    do_clear = 1'b0;
    do_bump  = 1'b0;
    if (eoi_valid) begin
      do_drop = 1'b1;
      if (!hit)                          do_bump  = !eoi_lpi;
      else if (split_mode && !eoi_lpi)   do_clear = 1'b0;
      else                               do_clear = agree;
    end else if (dir_valid && split_mode && !dir_lpi) begin
      if (hit) do_clear = 1'b1;
      else     do_bump  = 1'b1;
    end
  end

  assign do_phys = do_clear && hit_entry.hw;
  assign phys_id = hit_entry.pid;

endmodule

// File: rtl/virq_eoi_unit.sv
module virq_eoi_unit
  import virq_eoi_pkg::*;
#(
  parameter  int NUM_LR   = 8,
  parameter  int PRE_BITS = 5,
  parameter  int CNT_W    = 5,
  parameter  int LPI_BASE = 8192,
  localparam int IDX_W    = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              split_mode,
  input  logic [2:0]        bpr0,
  input  logic [2:0]        bpr1,
  input  logic              ld_valid,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [VID_W-1:0]  ld_vid,
  input  logic [PID_W-1:0]  ld_pid,
  input  logic [PRIO_W-1:0] ld_prio,
  input  logic              ld_grp,
  input  logic              ld_hw,
  input  logic              ld_active,
  input  logic              ap_set_valid,
  input  logic              ap_set_grp,
  input  logic [PRIO_W-1:0] ap_set_prio,
  input  logic              eoi_valid,
  input  logic              eoi_grp,
  input  logic [VID_W-1:0]  eoi_id,
  input  logic              dir_valid,
  input  logic [VID_W-1:0]  dir_id,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_active,
  output logic [PRIO_W-1:0] run_prio,
  output logic [CNT_W-1:0]  eoi_count,
  output logic              deact_valid,
  output logic [PID_W-1:0]  deact_pid
);

  lr_entry_t         ld_entry, hit_entry;
  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [VID_W-1:0]  srch_id;
  logic              do_drop, do_clear, do_bump, do_phys;
  logic [PID_W-1:0]  phys_id;
  logic [PRIO_W-1:0] act_prio, set_pre;

  always_comb begin
    ld_entry.hw     = ld_hw;
    ld_entry.grp    = ld_grp;
    ld_entry.active = ld_active;
    ld_entry.prio   = ld_prio;
    ld_entry.pid    = ld_pid;
    ld_entry.vid    = ld_vid;
  end

  assign set_pre = pre_level(ap_set_prio, ap_set_grp, bpr0, bpr1);

  virq_lr_bank #(.NUM_LR(NUM_LR)) lr_i (
    .clk       (clk),
    .rst       (rst),
    .ld_valid  (ld_valid),
    .ld_idx    (ld_idx),
    .ld_entry  (ld_entry),
    .clr_valid (do_clear),
    .clr_idx   (hit_idx),
    .srch_id   (srch_id),
    .hit       (hit),
    .hit_idx   (hit_idx),
    .hit_entry (hit_entry),
    .rd_idx    (rd_idx),
    .rd_active (rd_active)
  );

  virq_apr_tracker #(.PRE_BITS(PRE_BITS)) apr_i (
    .clk        (clk),
    .rst        (rst),
    .set_valid  (ap_set_valid),
    .set_grp    (ap_set_grp),
    .set_pre    (set_pre),
    .drop_valid (do_drop),
    .act_prio   (act_prio),
    .run_prio   (run_prio)
  );

  virq_eoi_decide #(.LPI_BASE(LPI_BASE)) dec_i (
    .eoi_valid  (eoi_valid),
    .eoi_grp    (eoi_grp),
    .eoi_id     (eoi_id),
    .dir_valid  (dir_valid),
    .dir_id     (dir_id),
    .split_mode (split_mode),
    .bpr0       (bpr0),
    .bpr1       (bpr1),
    .hit        (hit),
    .hit_entry  (hit_entry),
    .act_prio   (act_prio),
    .srch_id    (srch_id),
    .do_drop    (do_drop),
    .do_clear   (do_clear),
    .do_bump    (do_bump),
    .do_phys    (do_phys),
    .phys_id    (phys_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      eoi_count   <= '0;
      deact_valid <= 1'b0;
      deact_pid   <= '0;
    end else begin
      if (do_bump) eoi_count <= eoi_count + 1'b1;
      deact_valid <= do_phys;
      if (do_phys) deact_pid <= phys_id;
    end
  end

endmodule

// File: rtl/virq_eoi_chk.sv
module virq_eoi_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             eoi_valid,
  input logic             dir_valid,
  input logic             split_mode,
  input logic [CNT_W-1:0] eoi_count,
  input logic             deact_valid
);

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!eoi_valid && !dir_valid) |=> ($stable(eoi_count) && !deact_valid));

  // R9
  dir_off_chk: assert property (@(posedge clk) disable iff (rst)
    (dir_valid && !split_mode && !eoi_valid) |=> ($stable(eoi_count) && !deact_valid));

  // R11
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_count != $past(eoi_count)) |-> (eoi_count == CNT_W'($past(eoi_count) + 1'b1)));

  // R8
  pulse_no_miss_chk: assert property (@(posedge clk) disable iff (rst)
    deact_valid |-> $stable(eoi_count));

endmodule

bind virq_eoi_unit virq_eoi_chk #(.CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .eoi_valid   (eoi_valid),
  .dir_valid   (dir_valid),
  .split_mode  (split_mode),
  .eoi_count   (eoi_count),
  .deact_valid (deact_valid)
);

// File: tb/virq_eoi_unit_tb.sv
module virq_eoi_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        split_mode;
  logic [2:0]  bpr0, bpr1;
  logic        ld_valid;
  logic [2:0]  ld_idx;
  logic [15:0] ld_vid;
  logic [12:0] ld_pid;
  logic [7:0]  ld_prio;
  logic        ld_grp, ld_hw, ld_active;
  logic        ap_set_valid, ap_set_grp;
  logic [7:0]  ap_set_prio;
  logic        eoi_valid, eoi_grp;
  logic [15:0] eoi_id;
  logic        dir_valid;
  logic [15:0] dir_id;
  logic [2:0]  rd_idx;
  logic        rd_active;
  logic [7:0]  run_prio;
  logic [4:0]  eoi_count;
  logic        deact_valid;
  logic [12:0] deact_pid;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_cnt = 0;
  int dv1, pid1, dv2, cnt1;

  always #5 clk = ~clk;

  virq_eoi_unit dut_i (
    .clk(clk), .rst(rst), .split_mode(split_mode), .bpr0(bpr0), .bpr1(bpr1),
    .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_vid(ld_vid), .ld_pid(ld_pid),
    .ld_prio(ld_prio), .ld_grp(ld_grp), .ld_hw(ld_hw), .ld_active(ld_active),
    .ap_set_valid(ap_set_valid), .ap_set_grp(ap_set_grp), .ap_set_prio(ap_set_prio),
    .eoi_valid(eoi_valid), .eoi_grp(eoi_grp), .eoi_id(eoi_id),
    .dir_valid(dir_valid), .dir_id(dir_id), .rd_idx(rd_idx), .rd_active(rd_active),
    .run_prio(run_prio), .eoi_count(eoi_count), .deact_valid(deact_valid),
    .deact_pid(deact_pid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load(input int idx, input int vid, input int pid, input int prio,
                      input bit grp, input bit hw, input bit act);
    @(negedge clk);
    ld_valid = 1'b1; ld_idx = idx[2:0]; ld_vid = vid[15:0]; ld_pid = pid[12:0];
    ld_prio = prio[7:0]; ld_grp = grp; ld_hw = hw; ld_active = act;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic apset(input bit grp, input int prio);
    @(negedge clk);
    ap_set_valid = 1'b1; ap_set_grp = grp; ap_set_prio = prio[7:0];
    @(negedge clk);
    ap_set_valid = 1'b0;
    @(negedge clk);
  endtask

  // Drive one strobe cycle; capture the pulse cycle and the one after it.
  task automatic op(input bit e, input bit g, input int eid, input bit d, input int did);
    @(negedge clk);
    eoi_valid = e; eoi_grp = g; eoi_id = eid[15:0];
    dir_valid = d; dir_id = did[15:0];
    @(negedge clk);
    eoi_valid = 1'b0; dir_valid = 1'b0;
    dv1 = int'(deact_valid); pid1 = int'(deact_pid); cnt1 = int'(eoi_count);
    @(negedge clk);
    dv2 = int'(deact_valid);
  endtask

  task automatic rd(input int idx, output int a);
    rd_idx = idx[2:0];
    @(negedge clk);
    a = int'(rd_active);
  endtask

  task automatic t_reset;
    int a;
    chk("R1 count", int'(eoi_count), 0);
    chk("R1 pulse", int'(deact_valid), 0);
    chk("R1 run_prio", int'(run_prio), 255);
    for (int i = 0; i < 8; i++) begin
      rd(i, a);
      chk("R1 entry inactive", a, 0);
    end
  endtask

  task automatic t_basic;
    int a;
    load(0, 40, 700, 'h20, 1, 1, 1);
    apset(1, 'h20);
    chk("R2 run_prio after set", int'(run_prio), 'h20);
    op(1, 1, 40, 0, 0);
    chk("R8 pulse", dv1, 1);
    chk("R8 pid", pid1, 700);
    chk("R8 pulse one cycle", dv2, 0);
    chk("R8 count unchanged", cnt1, exp_cnt);
    chk("R3 level retired", int'(run_prio), 255);
    rd(0, a);
    chk("R8 active cleared", a, 0);
    load(1, 41, 5, 'h44, 0, 0, 1);
    apset(0, 'h44);
    chk("R2 group0 mask", int'(run_prio), 'h40);
    op(1, 0, 41, 0, 0);
    chk("R8 no pulse without hw", dv1, 0);
    rd(1, a);
    chk("R8 non-hw cleared", a, 0);
  endtask

  task automatic t_first_match;
    int a;
    load(0, 50, 99, 'h10, 1, 1, 0);
    load(1, 50, 11, 'h10, 1, 1, 1);
    load(3, 50, 33, 'h10, 1, 1, 1);
    apset(1, 'h10);
    op(1, 1, 50, 0, 0);
    chk("R4 lowest active wins", pid1, 11);
    rd(1, a);
    chk("R4 idx1 cleared", a, 0);
    rd(3, a);
    chk("R4 idx3 kept", a, 1);
    load(3, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_miss;
    op(1, 1, 77, 0, 0);
    exp_cnt = (exp_cnt + 1) % 32;
    chk("R5 miss counts", cnt1, exp_cnt);
    op(1, 1, 9000, 0, 0);
    chk("R5 lpi miss not counted", cnt1, exp_cnt);
    apset(0, 'h30);
    op(1, 0, 78, 0, 0);
    exp_cnt = (exp_cnt + 1) % 32;
    chk("R5 miss counts again", cnt1, exp_cnt);
    chk("R3 drop on miss", int'(run_prio), 255);
  endtask

  task automatic t_mismatch;
    int a;
    load(2, 60, 5, 'h20, 1, 1, 1);
    apset(1, 'h20);
    op(1, 0, 60, 0, 0);
    chk("R7 group mismatch no pulse", dv1, 0);
    chk("R7 group mismatch no count", cnt1, exp_cnt);
    chk("R3 drop on mismatch", int'(run_prio), 255);
    rd(2, a);
    chk("R7 group mismatch kept", a, 1);
    apset(1, 'h08);
    op(1, 1, 60, 0, 0);
    chk("R7 level mismatch no pulse", dv1, 0);
    rd(2, a);
    chk("R7 level mismatch kept", a, 1);
    apset(1, 'h20);
    op(1, 1, 60, 0, 0);
    chk("R7 agreement clears", dv1, 1);
    chk("R7 agreement pid", pid1, 5);
  endtask

  task automatic t_split;
    int a;
    split_mode = 1'b1;
    load(0, 70, 9, 'h18, 1, 1, 1);
    apset(1, 'h18);
    op(1, 1, 70, 0, 0);
    chk("R6 split no pulse", dv1, 0);
    chk("R6 split drop", int'(run_prio), 255);
    rd(0, a);
    chk("R6 split kept", a, 1);
    op(0, 0, 0, 1, 70);
    chk("R10 deactivate pulse", dv1, 1);
    chk("R10 deactivate pid", pid1, 9);
    rd(0, a);
    chk("R10 deactivate clears", a, 0);
    op(0, 0, 0, 1, 71);
    exp_cnt = (exp_cnt + 1) % 32;
    chk("R10 deactivate miss counts", cnt1, exp_cnt);
    load(1, 8200, 12, 'h18, 1, 1, 1);
    apset(1, 'h18);
    op(1, 1, 8200, 0, 0);
    chk("R6 lpi still deactivated", dv1, 1);
    chk("R6 lpi pid", pid1, 12);
  endtask

  task automatic t_dir_ignored;
    int a;
    load(2, 8300, 3, 'h18, 1, 1, 1);
    op(0, 0, 0, 1, 8300);
    chk("R9 lpi deactivate no pulse", dv1, 0);
    chk("R9 lpi deactivate no count", cnt1, exp_cnt);
    rd(2, a);
    chk("R9 lpi entry kept", a, 1);
    op(0, 0, 0, 1, 8400);
    chk("R9 lpi miss not counted", cnt1, exp_cnt);
    split_mode = 1'b0;
    load(0, 80, 4, 'h18, 1, 1, 1);
    op(0, 0, 0, 1, 80);
    chk("R9 non-split no pulse", dv1, 0);
    chk("R9 non-split no count", cnt1, exp_cnt);
    rd(0, a);
    chk("R9 non-split kept", a, 1);
  endtask

  task automatic t_both;
    int a;
    split_mode = 1'b1;
    op(1, 1, 99, 1, 80);
    exp_cnt = (exp_cnt + 1) % 32;
    chk("R12 completion counted", cnt1, exp_cnt);
    chk("R12 deactivate dropped", dv1, 0);
    rd(0, a);
    chk("R12 entry kept", a, 1);
    split_mode = 1'b0;
  endtask

  task automatic t_wrap;
    int steps;
    steps = 32 - exp_cnt;
    for (int i = 0; i < steps; i++) begin
      op(1, 0, 123, 0, 0);
      exp_cnt = (exp_cnt + 1) % 32;
      chk("R11 count step", cnt1, exp_cnt);
    end
    chk("R11 wrapped to zero", int'(eoi_count), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; split_mode = 1'b0; bpr0 = 3'd2; bpr1 = 3'd3;
    ld_valid = 1'b0; ld_idx = '0; ld_vid = '0; ld_pid = '0; ld_prio = '0;
    ld_grp = 1'b0; ld_hw = 1'b0; ld_active = 1'b0;
    ap_set_valid = 1'b0; ap_set_grp = 1'b0; ap_set_prio = '0;
    eoi_valid = 1'b0; eoi_grp = 1'b0; eoi_id = '0;
    dir_valid = 1'b0; dir_id = '0; rd_idx = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_basic;
    t_first_match;
    t_miss;
    t_mismatch;
    t_split;
    t_dir_ignored;
    t_both;
    t_wrap;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule